// File: doc/BRIEF.md
# Carrier Window Demodulator

This block sits ahead of a pulse-width measuring receiver and turns a carrier-modulated infrared input into a baseband mark/space level. It synchronizes the raw input and detects its rising edges. It then measures the spacing of successive rising edges in receive ticks. The ticks come from a prescaler that is shared with the receiver and arrive here as a one-cycle enable. A nominal carrier cycle lasts 16 ticks. An edge whose spacing lies inside a selectable tolerance window proves that a carrier burst is present, and the output reports mark.

The tolerance window is asymmetric and chosen by a 2-bit code. Code bit 1 widens the short side from 3 to 4 ticks below nominal. Code bit 0 widens the long side from 3 to 4 ticks above nominal. When demodulation is switched off, the synchronized input goes straight to the output and the window logic is held idle.

The control is a three-state machine:
- IDLE: no reference edge exists.
- ARMED: a reference edge was seen, but no in-window interval has followed it yet.
- MARK: a carrier has been confirmed.

Its transitions are:
- IDLE to ARMED on any rising edge.
- ARMED to MARK on an in-window edge.
- ARMED to ARMED, restarting the count, on an out-of-window edge.
- MARK to MARK on an in-window edge.
- MARK to ARMED on an out-of-window edge.
- ARMED or MARK to IDLE once 21 ticks pass with no edge.
- Any state to IDLE while demodulation is off.

Top module: `carrier_window_demod`

## Requirements
- R1: During and after reset, `bb_out` is 0 and the state machine is IDLE.
- R2: With `demod_en` low, `bb_out` equals `ir_in` delayed by exactly three clock edges: two synchronizer stages plus the output register.
- R3: The accepted interval is 13..19 ticks when `win_code`=00, 13..20 when 01, 12..19 when 10, and 12..20 when 11. Bit 1 lowers the lower limit by one and bit 0 raises the upper limit by one.
- R4: An interval is the number of cycles with `tick_en` high from the cycle of one synchronized rising edge up to the cycle before the next one. Only rising edges are counted, so the duty cycle has no effect.
- R5: The first rising edge after IDLE only arms the block (output stays space). A later edge with an in-window interval sets `bb_out` to 1 one cycle after the edge is detected.
- R6: A rising edge with an out-of-window interval drives `bb_out` to 0 and restarts the interval count from that edge.
- R7: When 21 ticks accumulate with no rising edge while ARMED or MARK, the block returns to IDLE and `bb_out` falls to 0. The interval counter saturates at 21.
- R8: Dropping `demod_en` forces the state machine to IDLE and clears the counter, so re-enabling it never resumes an earlier mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle receive tick from the shared prescaler |
| demod_en | input | 1 | 1 selects the windowed demodulator, 0 selects bypass |
| win_code | input | 2 | Tolerance window select (see R3) |
| ir_in | input | 1 | Asynchronous modulated infrared input |
| bb_out | output | 1 | Baseband mark (1) / space (0) level |

## Verification
In bypass, a change on `ir_in` appears on `bb_out` after exactly three rising clock edges. The bench samples just after the second edge, to see the old value, and just after the third, to see the new one. In demodulation mode, a rising edge is detected two edges after `ir_in` rises, and `bb_out` reacts one edge later. Every demodulation check is therefore taken at the end of a carrier burst, when the last edge is at least three cycles old and still well short of the 21-tick timeout. The timeout is checked on both sides of its deadline: the output must still read mark 4 cycles after the burst ends and must read space 16 cycles after it ends.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_MARK  = 2'd2
    } cwd_state_e;

    // Lower acceptance limit: nominal minus narrow or wide slack.
    function automatic int unsigned lo_limit(input int unsigned nom,
                                             input int unsigned narrow,
                                             input int unsigned wide,
                                             input logic widen);
        return widen ? (nom - wide) : (nom - narrow);
    endfunction

    // Upper acceptance limit: nominal plus narrow or wide slack.
    function automatic int unsigned hi_limit(input int unsigned nom,
                                             input int unsigned narrow,
                                             input int unsigned wide,
                                             input logic widen);
        return widen ? (nom + wide) : (nom + narrow);
    endfunction

endpackage

// File: rtl/cwd_sync.sv
module cwd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic rise
);
    logic [STAGES-1:0] pipe_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= {pipe_q[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pipe_q[STAGES-1];
    end

    assign lvl  = pipe_q[STAGES-1];
    assign rise = pipe_q[STAGES-1] & ~prev_q;

    // R4
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/cwd_interval.sv
module cwd_interval #(
    parameter int unsigned LIMIT = 21,
    localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick_en,
    input  logic          rise,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (rise)
            cnt_q <= tick_en ? CW'(1) : '0;
        else if (tick_en && cnt_q != LIM)
            cnt_q <= cnt_q + CW'(1);
    end

    assign count = cnt_q;

    // R4
    restart_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> count <= CW'(1));

    // R7
    count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LIM);

    // R8
    count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> count == '0);
endmodule

// File: rtl/cwd_fsm.sv
module cwd_fsm
    import cwd_pkg::*;
#(
    parameter int unsigned NOM    = 16,
    parameter int unsigned NARROW = 3,
    parameter int unsigned WIDE   = 4,
    parameter int unsigned LIMIT  = 21,
    localparam int unsigned CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          demod_en,
    input  logic [1:0]    win_code,
    input  logic          rise,
    input  logic          lvl,
    input  logic [CW-1:0] count,
    output logic          bb_out
);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    cwd_state_e    st_q, st_d;
    logic [CW-1:0] lo_b, hi_b;
    logic          in_win;
    logic          expired;
    logic          bb_q;

    always_comb begin
        lo_b    = CW'(lo_limit(NOM, NARROW, WIDE, win_code[1]));
        hi_b    = CW'(hi_limit(NOM, NARROW, WIDE, win_code[0]));
        in_win  = (count >= lo_b) && (count <= hi_b);
        expired = (count >= LIM);
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (!demod_en) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:  if (rise) st_d = ST_ARMED;
                ST_ARMED: begin
                    if (rise)         st_d = in_win ? ST_MARK : ST_ARMED;
                    else if (expired) st_d = ST_IDLE;
                end
                ST_MARK: begin
                    if (rise)         st_d = in_win ? ST_MARK : ST_ARMED;
                    else if (expired) st_d = ST_IDLE;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bb_q <= 1'b0;
        else        bb_q <= demod_en ? (st_d == ST_MARK) : lvl;
    end

    assign bb_out = bb_q;

    // R1
    legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q inside {ST_IDLE, ST_ARMED, ST_MARK});

    // R5
    arm_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (demod_en && st_q == ST_IDLE && rise) |=> (st_q == ST_ARMED && !bb_out));

    // R6
    reject_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (demod_en && st_q != ST_IDLE && rise && !in_win) |=> (st_q == ST_ARMED && !bb_out));

    // R7
    timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (demod_en && !rise && count == LIM) |=> st_q == ST_IDLE);

    // R8
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !demod_en |=> st_q == ST_IDLE);
endmodule

// File: rtl/carrier_window_demod.sv
module carrier_window_demod #(
    parameter int unsigned NOM_TICKS   = 16,
    parameter int unsigned NARROW_TOL  = 3,
    parameter int unsigned WIDE_TOL    = 4,
    parameter int unsigned SLACK       = 1,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       demod_en,
    input  logic [1:0] win_code,
    input  logic       ir_in,
    output logic       bb_out
);
    localparam int unsigned LIMIT = NOM_TICKS + WIDE_TOL + SLACK;
    localparam int unsigned CW    = $clog2(LIMIT + 1);

    logic          lvl;
    logic          rise;
    logic [CW-1:0] count;

    cwd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ir_in),
        .lvl  (lvl),
        .rise (rise)
    );

    cwd_interval #(.LIMIT(LIMIT)) u_interval (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (demod_en),
        .tick_en(tick_en),
        .rise   (rise),
        .count  (count)
    );

    cwd_fsm #(
        .NOM   (NOM_TICKS),
        .NARROW(NARROW_TOL),
        .WIDE  (WIDE_TOL),
        .LIMIT (LIMIT)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .demod_en(demod_en),
        .win_code(win_code),
        .rise    (rise),
        .lvl     (lvl),
        .count   (count),
        .bb_out  (bb_out)
    );

    // R2
    bypass_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, SYNC_STAGES + 1) && !$past(demod_en))
            |-> bb_out == $past(ir_in, SYNC_STAGES + 1));
endmodule

// File: tb/carrier_window_demod_tb.sv
module carrier_window_demod_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       demod_en = 1'b0;
    logic [1:0] win_code = 2'b00;
    logic       ir_in = 1'b0;
    logic       bb_out;

    int total = 0;
    int bad = 0;
    int tcnt = 0;
    int tdiv = 1;

    always #4 clk = ~clk;

    carrier_window_demod u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .demod_en(demod_en),
        .win_code(win_code),
        .ir_in   (ir_in),
        .bb_out  (bb_out)
    );

    // Vector fields: code[18:17] period[16:10] high[9:3] tick_div[2:1] expect[0]
    localparam int NV = 16;
    localparam logic [18:0] VEC [NV] = '{
        {2'd0, 7'd16, 7'd8,  2'd1, 1'b1},
        {2'd0, 7'd13, 7'd6,  2'd1, 1'b1},
        {2'd0, 7'd19, 7'd9,  2'd1, 1'b1},
        {2'd0, 7'd12, 7'd6,  2'd1, 1'b0},
        {2'd0, 7'd20, 7'd10, 2'd1, 1'b0},
        {2'd1, 7'd20, 7'd10, 2'd1, 1'b1},
        {2'd1, 7'd12, 7'd6,  2'd1, 1'b0},
        {2'd2, 7'd12, 7'd6,  2'd1, 1'b1},
        {2'd2, 7'd20, 7'd10, 2'd1, 1'b0},
        {2'd3, 7'd12, 7'd6,  2'd1, 1'b1},
        {2'd3, 7'd20, 7'd10, 2'd1, 1'b1},
        {2'd3, 7'd11, 7'd5,  2'd1, 1'b0},
        {2'd3, 7'd21, 7'd10, 2'd1, 1'b0},
        {2'd0, 7'd16, 7'd3,  2'd1, 1'b1},
        {2'd0, 7'd32, 7'd16, 2'd2, 1'b1},
        {2'd0, 7'd32, 7'd16, 2'd1, 1'b0}
    };

    task automatic cyc(input logic lvl);
        @(negedge clk);
        ir_in   = lvl;
        tick_en = (tdiv == 1) ? 1'b1 : tcnt[0];
        tcnt++;
    endtask

    task automatic burst(input int period, input int high, input int n);
        for (int p = 0; p < n; p++) begin
            for (int c = 0; c < period; c++) cyc(c < high);
        end
    endtask

    task automatic idle(input int n);
        for (int c = 0; c < n; c++) cyc(1'b0);
    endtask

    task automatic check(input string req, input logic exp);
        total++;
        if (bb_out !== exp) begin
            bad++;
            $display("FAIL %s: bb_out=%b expected=%b", req, bb_out, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1", 1'b0);
        rst_n = 1'b1;

        // R2 bypass latency: old value after two edges, new after three
        demod_en = 1'b0;
        idle(4);
        cyc(1'b1);
        cyc(1'b1);
        cyc(1'b1);
        check("R2", 1'b0);
        cyc(1'b1);
        check("R2", 1'b1);
        cyc(1'b0);
        idle(3);
        check("R2", 1'b0);

        // R3/R4/R5 table walk
        demod_en = 1'b1;
        for (int i = 0; i < NV; i++) begin
            win_code = VEC[i][18:17];
            tdiv     = int'(VEC[i][2:1]);
            idle(60);
            burst(int'(VEC[i][16:10]), int'(VEC[i][9:3]), 4);
            check($sformatf("R3 R4 vector %0d", i), VEC[i][0]);
        end
        tdiv = 1;
        win_code = 2'b00;

        // R6 out-of-window edge drops mark, then recovers
        idle(60);
        burst(16, 8, 4);
        burst(10, 5, 1);
        for (int c = 0; c < 5; c++) cyc(1'b1);
        check("R6", 1'b0);
        for (int c = 0; c < 3; c++) cyc(1'b1);
        idle(8);
        burst(16, 8, 1);
        check("R5", 1'b1);

        // R7 timeout on both sides of its deadline
        idle(60);
        burst(16, 8, 4);
        idle(4);
        check("R7", 1'b1);
        idle(12);
        check("R7", 1'b0);

        // R8 disabling clears state; R5 first edge only arms
        idle(60);
        burst(16, 8, 4);
        check("R8", 1'b1);
        demod_en = 1'b0;
        idle(4);
        check("R8", 1'b0);
        demod_en = 1'b1;
        idle(3);
        check("R8", 1'b0);
        burst(16, 8, 1);
        check("R5", 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule